// File: doc/BRIEF.md
# Miss Wait Register Bank

This block keeps track of cache misses while the line is being fetched from memory. Each of the two request pipelines owns a small set of wait registers. A miss placed in a wait register counts down the memory latency and, when the count runs out, the bank issues a memory-return request that carries the miss's identity back to the cache. A pipeline whose wait registers are all busy spills its misses into an overflow pair shared by both pipelines. The pair holds up to two entries in arrival order. When a wait register frees up, it takes a waiting overflow entry of its own pipeline.

The cache presents one miss per cycle with its pipeline, request number, address, urgency and request kind. The bank answers with at most one return request per cycle. If neither a wait register nor an overflow slot can take the miss, it raises a retry flag one cycle later and drops the miss. Every stored entry records an urgency one step higher than the request that created it, so the follow-up work runs ahead of newer traffic. Urgency counts down: 0 is the most urgent value.

Top module: `mwb_miss_wait_bank`

## Requirements
- R1: After reset, `ret_valid` and `retry` are low and every wait register and overflow slot is empty.
- R2: A miss takes the lowest-numbered free wait register of its pipeline. Each pipeline tracks NWAIT misses at once without retry.
- R3: A miss that enters a wait register at clock edge A produces its return request in the cycle after edge A+LATENCY+1. The default LATENCY is 20.
- R4: A return request carries the miss's pipeline, request number and address. Its priority is the request's priority minus one, and a request priority of 0 stays 0.
- R5: `miss_kind` encoding: 2'b00 load sets preload 0 and lock 0. 2'b01 store sets preload 1 and lock 0. 2'b10 preload sets preload 1 and takes `miss_lock` as lock. 2'b11 is treated as a load. `miss_lock` has no effect on load and store.
- R6: A wait register whose count has expired and that was not chosen stays pending and is emitted on a later cycle. At most one return request is issued per cycle.
- R7: When the miss's pipeline has no free wait register, the miss goes to the primary overflow slot if that slot is empty, otherwise to the secondary slot. If both are occupied, `retry` is high in the following cycle and the miss is dropped.
- R8: A wait register freed by a return first takes the primary overflow entry if that entry belongs to the same pipeline, and the secondary entry then moves up to primary. Otherwise it takes the secondary entry if that one belongs to the same pipeline. A promoted entry restarts its count at LATENCY+1, so its return comes LATENCY+1 edges after the promoting edge.
- R10: When several wait registers are pending at once, the lowest index goes first. The index is pipe*NWAIT + register.
- R11: A miss presented in the cycle in which a wait register or overflow slot is freed can use that freed place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_pipe | input | PIPE_W | Pipeline of the miss |
| miss_reqno | input | REQNO_W | Request number |
| miss_addr | input | ADDR_W | Miss address |
| miss_prio | input | PRIO_W | Request priority (0 is most urgent) |
| miss_kind | input | 2 | Request kind, encoded as in R5 |
| miss_lock | input | 1 | Lock flag of a preload |
| ret_valid | output | 1 | Return request issued |
| ret_pipe | output | PIPE_W | Pipeline of the returned miss |
| ret_reqno | output | REQNO_W | Request number |
| ret_addr | output | ADDR_W | Address |
| ret_prio | output | PRIO_W | Stored priority |
| ret_preload | output | 1 | Preload flag |
| ret_lock | output | 1 | Lock flag |
| retry | output | 1 | Previous cycle's miss found no room |

## Verification
A miss sampled at edge A is expected at the return port after edge A+LATENCY+1. A promoted entry is expected LATENCY+1 edges after the edge of the return that freed its register. The retry flag is expected after the edge that sampled the rejected miss. The bench numbers the clock edges, notes the edge at which each miss is sampled, and logs the edge number and fields of every return it sees. Each check compares the logged edge number with the exact expected one, so a return that comes one cycle early or late, or in the wrong order, is reported.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  parameter int ADDR_W  = 32;
  parameter int REQNO_W = 8;
  parameter int PRIO_W  = 6;
  parameter int PIPE_W  = 1;

  typedef enum logic [1:0] {
    KIND_LOAD    = 2'd0,
    KIND_STORE   = 2'd1,
    KIND_PRELOAD = 2'd2
  } miss_kind_e;

  typedef struct packed {
    logic [PIPE_W-1:0]  pipe;
    logic [REQNO_W-1:0] reqno;
    logic [ADDR_W-1:0]  addr;
    logic [PRIO_W-1:0]  prio;
    logic               preload;
    logic               lock;
  } miss_entry_t;
endpackage

// File: rtl/mwb_wait_slot.sv
module mwb_wait_slot
  import mwb_pkg::*;
#(
  parameter int LATENCY = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  miss_entry_t load_entry,
  input  logic        drop,
  output logic        valid,
  output logic        due,
  output miss_entry_t entry
);
  localparam int CNT_W = $clog2(LATENCY + 2);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LATENCY + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cnt   <= RELOAD;
      entry <= load_entry;
    end else if (drop) begin
      valid <= 1'b0;
    end else if (valid && cnt > 1) begin
      cnt <= cnt - 1'b1;
    end
  end

  // expired: the count reaches zero at the next edge
  assign due = valid && (cnt <= 1);

  // R6: an expired register keeps waiting until it is chosen
  p_due_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (due && !drop && !load) |=> due);

  // R6: only an expired register is released
  p_drop_only_due_r6: assert property (@(posedge clk) disable iff (rst)
    drop |-> due);
endmodule

// File: rtl/mwb_due_pick.sv
module mwb_due_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     due,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (due[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mwb_overflow_pair.sv
module mwb_overflow_pair
  import mwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take_primary,
  input  logic              take_secondary,
  input  logic              push,
  input  miss_entry_t       push_entry,
  output logic [1:0]        hold_valid,
  output miss_entry_t [1:0] hold_entry,
  output logic              push_ok
);
  logic [1:0]        mid_v, nxt_v;
  miss_entry_t [1:0] mid_e, nxt_e;

  always_comb begin
    mid_v = hold_valid;
    mid_e = hold_entry;
    if (take_primary) begin
      mid_v[0] = hold_valid[1];
      mid_e[0] = hold_entry[1];
      mid_v[1] = 1'b0;
    end else if (take_secondary) begin
      mid_v[1] = 1'b0;
    end
    push_ok = !mid_v[0] || !mid_v[1];
    nxt_v = mid_v;
    nxt_e = mid_e;
    if (push) begin
      if (!mid_v[0]) begin
        nxt_v[0] = 1'b1;
        nxt_e[0] = push_entry;
      end else if (!mid_v[1]) begin
        nxt_v[1] = 1'b1;
        nxt_e[1] = push_entry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hold_valid <= '0;
    else     hold_valid <= nxt_v;
    hold_entry <= nxt_e;
  end

  // R7: the secondary slot is never occupied while the primary is empty
  p_pair_order_r7: assert property (@(posedge clk) disable iff (rst)
    hold_valid[1] |-> hold_valid[0]);

  // R8: promotion only takes an occupied slot
  p_take_occupied_r8: assert property (@(posedge clk) disable iff (rst)
    (take_primary |-> hold_valid[0]) and (take_secondary |-> hold_valid[1]));
endmodule

// File: rtl/mwb_miss_wait_bank.sv
module mwb_miss_wait_bank
  import mwb_pkg::*;
#(
  parameter int NPIPE   = 2,
  parameter int NWAIT   = 2,
  parameter int LATENCY = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  input  logic [PIPE_W-1:0]  miss_pipe,
  input  logic [REQNO_W-1:0] miss_reqno,
  input  logic [ADDR_W-1:0]  miss_addr,
  input  logic [PRIO_W-1:0]  miss_prio,
  input  logic [1:0]         miss_kind,
  input  logic               miss_lock,
  output logic               ret_valid,
  output logic [PIPE_W-1:0]  ret_pipe,
  output logic [REQNO_W-1:0] ret_reqno,
  output logic [ADDR_W-1:0]  ret_addr,
  output logic [PRIO_W-1:0]  ret_prio,
  output logic               ret_preload,
  output logic               ret_lock,
  output logic               retry
);
  localparam int NSLOT  = NPIPE * NWAIT;
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  miss_entry_t        new_entry;
  miss_entry_t        promo_entry;
  miss_entry_t        slot_entry [NSLOT];
  logic [NSLOT-1:0]   slot_valid, slot_due, released, promo_load, free_mid, slot_load;
  logic               sel_any;
  logic [SLOT_W-1:0]  sel_idx;
  logic [PIPE_W-1:0]  free_pipe;
  logic               take_primary, take_secondary;
  logic [1:0]         hold_valid;
  miss_entry_t [1:0]  hold_entry;
  logic               alloc_hit, push, push_ok;
  logic [SLOT_W-1:0]  alloc_slot;
  miss_entry_t        ret_q;

  // entry built from the incoming miss (R4, R5)
  always_comb begin
    new_entry       = '0;
    new_entry.pipe  = miss_pipe;
    new_entry.reqno = miss_reqno;
    new_entry.addr  = miss_addr;
    new_entry.prio  = (miss_prio == '0) ? '0 : miss_prio - 1'b1;
    unique case (miss_kind)
      KIND_STORE:   begin new_entry.preload = 1'b1; new_entry.lock = 1'b0;      end
      KIND_PRELOAD: begin new_entry.preload = 1'b1; new_entry.lock = miss_lock; end
      default:      begin new_entry.preload = 1'b0; new_entry.lock = 1'b0;      end
    endcase
  end

  mwb_due_pick #(.N(NSLOT)) pick_i (
    .due (slot_due),
    .any (sel_any),
    .idx (sel_idx)
  );

  assign free_pipe      = PIPE_W'(32'(sel_idx) / NWAIT);
  assign take_primary   = sel_any && hold_valid[0] && (hold_entry[0].pipe == free_pipe);
  assign take_secondary = sel_any && !take_primary && hold_valid[1] &&
                          (hold_entry[1].pipe == free_pipe);
  assign promo_entry    = take_primary ? hold_entry[0] : hold_entry[1];

  // first free wait register of the miss's pipe, after this cycle's release
  always_comb begin
    alloc_hit  = 1'b0;
    alloc_slot = '0;
    for (int w = NWAIT - 1; w >= 0; w--) begin
      if ((int'(miss_pipe) * NWAIT + w) < NSLOT) begin
        if (free_mid[int'(miss_pipe) * NWAIT + w]) begin
          alloc_hit  = 1'b1;
          alloc_slot = SLOT_W'(int'(miss_pipe) * NWAIT + w);
        end
      end
    end
  end

  assign push = miss_valid && !alloc_hit;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign released[s]   = sel_any && (sel_idx == SLOT_W'(s));
    assign promo_load[s] = released[s] && (take_primary || take_secondary);
    assign free_mid[s]   = !slot_valid[s] || (released[s] && !promo_load[s]);
    assign slot_load[s]  = promo_load[s] ||
                           (miss_valid && alloc_hit && (alloc_slot == SLOT_W'(s)));

    mwb_wait_slot #(.LATENCY(LATENCY)) slot_i (
      .clk        (clk),
      .rst        (rst),
      .load       (slot_load[s]),
      .load_entry (promo_load[s] ? promo_entry : new_entry),
      .drop       (released[s]),
      .valid      (slot_valid[s]),
      .due        (slot_due[s]),
      .entry      (slot_entry[s])
    );

    if (s > 0) begin : g_low
      // R10: no lower-indexed register is pending when this one is released
      p_lowest_first_r10: assert property (@(posedge clk) disable iff (rst)
        released[s] |-> !(|slot_due[s-1:0]));
    end
  end

  mwb_overflow_pair pair_i (
    .clk            (clk),
    .rst            (rst),
    .take_primary   (take_primary),
    .take_secondary (take_secondary),
    .push           (push),
    .push_entry     (new_entry),
    .hold_valid     (hold_valid),
    .hold_entry     (hold_entry),
    .push_ok        (push_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      retry     <= 1'b0;
    end else begin
      ret_valid <= sel_any;
      retry     <= push && !push_ok;
    end
    if (sel_any) ret_q <= slot_entry[sel_idx];
  end

  assign ret_pipe    = ret_q.pipe;
  assign ret_reqno   = ret_q.reqno;
  assign ret_addr    = ret_q.addr;
  assign ret_prio    = ret_q.prio;
  assign ret_preload = ret_q.preload;
  assign ret_lock    = ret_q.lock;

  // R10: a single register is released per cycle
  p_one_release_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(released));

  // R7: retry only follows a cycle with both overflow slots occupied
  p_retry_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    retry |-> $past(hold_valid == 2'b11));

  // R6: a return always stems from an expired register
  p_ret_from_due_r6: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(|slot_due));
endmodule

// File: tb/mwb_miss_wait_bank_tb_top.sv
`timescale 1ns/1ps
module mwb_miss_wait_bank_tb_top;
  import mwb_pkg::*;

  localparam int LAT = 6;
  localparam int L1  = LAT + 1;
  localparam int NV  = 6;

  // vector table: pipe, reqno, addr, prio, kind, lock -> preload, lock, prio
  localparam int V_PIPE [NV] = '{0, 1, 0, 1, 0, 1};
  localparam int V_RQ   [NV] = '{11, 12, 13, 14, 15, 16};
  localparam int V_ADDR [NV] = '{32'h1000, 32'h2040, 32'h3080, 32'h40c0, 32'h5100, 32'h6140};
  localparam int V_PRIO [NV] = '{5, 9, 1, 0, 63, 7};
  localparam int V_KIND [NV] = '{0, 1, 2, 2, 0, 3};
  localparam int V_LOCK [NV] = '{0, 1, 1, 0, 1, 1};
  localparam int E_PRE  [NV] = '{0, 1, 1, 1, 0, 0};
  localparam int E_LOCK [NV] = '{0, 0, 1, 0, 0, 0};
  localparam int E_PRIO [NV] = '{4, 8, 0, 0, 62, 6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic miss_valid = 1'b0;
  logic [PIPE_W-1:0]  miss_pipe = '0;
  logic [REQNO_W-1:0] miss_reqno = '0;
  logic [ADDR_W-1:0]  miss_addr = '0;
  logic [PRIO_W-1:0]  miss_prio = '0;
  logic [1:0]         miss_kind = '0;
  logic               miss_lock = 1'b0;
  logic ret_valid, ret_preload, ret_lock, retry;
  logic [PIPE_W-1:0]  ret_pipe;
  logic [REQNO_W-1:0] ret_reqno;
  logic [ADDR_W-1:0]  ret_addr;
  logic [PRIO_W-1:0]  ret_prio;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int nlog = 0;
  int log_rq [32];
  int log_cyc [32];
  int log_pipe [32];
  int log_addr [32];
  int log_prio [32];
  int log_pre [32];
  int log_lock [32];

  mwb_miss_wait_bank #(.NPIPE(2), .NWAIT(2), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_pipe(miss_pipe),
    .miss_reqno(miss_reqno), .miss_addr(miss_addr), .miss_prio(miss_prio),
    .miss_kind(miss_kind), .miss_lock(miss_lock), .ret_valid(ret_valid),
    .ret_pipe(ret_pipe), .ret_reqno(ret_reqno), .ret_addr(ret_addr),
    .ret_prio(ret_prio), .ret_preload(ret_preload), .ret_lock(ret_lock),
    .retry(retry)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && ret_valid && nlog < 32) begin
      log_rq[nlog]   = int'(ret_reqno);
      log_cyc[nlog]  = cyc;
      log_pipe[nlog] = int'(ret_pipe);
      log_addr[nlog] = int'(ret_addr);
      log_prio[nlog] = int'(ret_prio);
      log_pre[nlog]  = int'(ret_preload);
      log_lock[nlog] = int'(ret_lock);
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    miss_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nlog = 0;
  endtask

  // drive at a falling edge; the miss is sampled at edge number 'ed'
  task automatic issue(input int p, input int r, input int a, input int pr,
                       input int k, input int l, output int ed);
    miss_pipe  = PIPE_W'(p);
    miss_reqno = REQNO_W'(r);
    miss_addr  = ADDR_W'(a);
    miss_prio  = PRIO_W'(pr);
    miss_kind  = 2'(k);
    miss_lock  = l[0];
    miss_valid = 1'b1;
    ed = cyc + 1;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic expect_ret(input string req, input int i, input int rq, input int ed);
    chk({req, " reqno"}, log_rq[i], rq);
    chk({req, " edge"}, log_cyc[i], ed);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    int a0, a1, a2, a3, a4, a5, t;

    // R1: reset state
    do_reset();
    chk("R1 ret_valid after reset", int'(ret_valid), 0);
    chk("R1 retry after reset", int'(retry), 0);
    repeat (L1 + 2) @(negedge clk);
    chk("R1 no return from an empty bank", nlog, 0);

    // R3 R4 R5: vector table, one miss at a time
    for (int v = 0; v < NV; v++) begin
      do_reset();
      issue(V_PIPE[v], V_RQ[v], V_ADDR[v], V_PRIO[v], V_KIND[v], V_LOCK[v], a0);
      repeat (L1 + 3) @(negedge clk);
      chk("R3 one return", nlog, 1);
      chk("R3 return edge", log_cyc[0], a0 + L1);
      chk("R4 pipe", log_pipe[0], V_PIPE[v]);
      chk("R4 reqno", log_rq[0], V_RQ[v]);
      chk("R4 addr", log_addr[0], V_ADDR[v]);
      chk("R4 prio minus one", log_prio[0], E_PRIO[v]);
      chk("R5 preload flag", log_pre[0], E_PRE[v]);
      chk("R5 lock flag", log_lock[0], E_LOCK[v]);
    end

    // R2 R7 R8: fill pipe 0, overflow into both slots, then retry
    do_reset();
    issue(0, 1, 32'h100, 4, 0, 0, a0);
    chk("R2 first register no retry", int'(retry), 0);
    issue(0, 2, 32'h140, 4, 0, 0, a1);
    chk("R2 second register no retry", int'(retry), 0);
    issue(0, 3, 32'h180, 4, 0, 0, a2);
    chk("R7 primary slot no retry", int'(retry), 0);
    issue(1, 4, 32'h1c0, 4, 0, 0, a3);
    chk("R2 other pipe free register", int'(retry), 0);
    issue(0, 5, 32'h200, 4, 0, 0, a4);
    chk("R7 secondary slot no retry", int'(retry), 0);
    issue(0, 6, 32'h240, 4, 0, 0, a5);
    chk("R7 retry when all full", int'(retry), 1);
    @(negedge clk);
    chk("R7 retry drops after one cycle", int'(retry), 0);
    repeat (3 * L1) @(negedge clk);
    chk("R7 dropped miss never returns", nlog, 5);
    expect_ret("R2", 0, 1, a0 + L1);
    expect_ret("R2", 1, 2, a1 + L1);
    expect_ret("R2", 2, 4, a3 + L1);
    expect_ret("R8 primary promoted", 3, 3, a0 + 2 * L1);
    expect_ret("R8 secondary moved up", 4, 5, a1 + 2 * L1);
    chk("R4 overflow entry prio", log_prio[3], 3);

    // R8: primary from other pipe, secondary taken by the freed register
    do_reset();
    issue(0, 21, 32'h1000, 2, 0, 0, a0);
    issue(0, 22, 32'h1040, 2, 0, 0, a1);
    issue(1, 23, 32'h1080, 2, 0, 0, a2);
    issue(1, 24, 32'h10c0, 2, 0, 0, a3);
    issue(1, 25, 32'h1100, 2, 0, 0, a4);
    issue(0, 26, 32'h1140, 2, 0, 0, a5);
    chk("R7 pipe mix no retry", int'(retry), 0);
    repeat (3 * L1) @(negedge clk);
    chk("R8 six returns", nlog, 6);
    expect_ret("R8", 0, 21, a0 + L1);
    expect_ret("R8", 1, 22, a1 + L1);
    expect_ret("R8", 2, 23, a2 + L1);
    expect_ret("R8", 3, 24, a3 + L1);
    expect_ret("R8 secondary promoted", 4, 26, a0 + 2 * L1);
    expect_ret("R8 primary promoted later", 5, 25, a2 + 2 * L1);

    // R10 R6: promotion and new miss expire on the same edge
    do_reset();
    issue(0, 31, 32'h2000, 3, 0, 0, a0);
    issue(0, 32, 32'h2040, 3, 0, 0, a1);
    issue(0, 33, 32'h2080, 3, 0, 0, a2);
    while (cyc + 1 < a0 + L1) @(negedge clk);
    issue(1, 34, 32'h20c0, 3, 0, 0, t);
    chk("R10 miss on promoting edge", t, a0 + L1);
    repeat (3 * L1) @(negedge clk);
    chk("R10 four returns", nlog, 4);
    expect_ret("R10", 0, 31, a0 + L1);
    expect_ret("R10", 1, 32, a1 + L1);
    expect_ret("R10 lower index first", 2, 33, a0 + 2 * L1);
    expect_ret("R6 pending one waits", 3, 34, a0 + 2 * L1 + 1);

    // R11: miss uses the register freed in the same cycle
    do_reset();
    issue(0, 41, 32'h3000, 3, 0, 0, a0);
    issue(0, 42, 32'h3040, 3, 0, 0, a1);
    while (cyc + 1 < a0 + L1) @(negedge clk);
    issue(0, 43, 32'h3080, 3, 0, 0, t);
    chk("R11 no retry", int'(retry), 0);
    repeat (2 * L1) @(negedge clk);
    chk("R11 three returns", nlog, 3);
    expect_ret("R11 freed register reused", 2, 43, t + L1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule